// File: doc/BRIEF.md
# Lockstep Compare Status Register

This block is the status word for a dual-core lockstep comparator. It holds a sticky compare-error flag that the comparator raises whenever the two cores' compared outputs disagree. Only privileged software can clear that flag, by writing a one to its bit. The same word also reports the outcome of a two-phase comparator self-test. The first phase checks that matching inputs give no error. The second phase checks that forced mismatches are detected. The self-test controller drives a done pulse, a failure pulse and a phase indicator, and the block turns these into a completion flag, a pass/fail flag and a flag naming the failing phase.

A plain register bus reaches the block. It carries an address, a write strobe, write data, a privilege qualifier and combinational read data. The self-test flags are visible only while the operating mode input selects self-test. They are held cleared in every other mode, so each new run starts from zero. The first failure seen in a run is latched and kept, so later activity in that run cannot overwrite it.

Top module: `lockstep_cmp_status`

## Requirements
- R1: The word at address `REG_ADDR` (default 0) holds the compare error at bit 16, self-test complete at bit 8, self-test error type at bit 1 and self-test error at bit 0, and every other bit reads 0. When `FULL_DECODE` is 1 (the default), a read at any other address returns 0.
- R2: A cycle with `cmp_mismatch` high sets the compare error bit on that clock edge, and the bit then stays 1 until it is cleared.
- R3: A write with `bus_priv` high and `bus_wdata[16]` = 1 to the register address clears the compare error bit. The same write with `bus_wdata[16]` = 0 leaves the bit unchanged.
- R4: A write with `bus_priv` low never changes the compare error bit.
- R5: When a mismatch and a privileged clear write fall in the same cycle, the compare error bit ends up 1.
- R6: While `mode_selftest` is 0, the complete, error and error-type bits read 0 and are held cleared. A run that starts after leaving self-test mode therefore begins with all three at 0.
- R7: In self-test mode, complete reads 0 until a `st_done` pulse arrives and reads 1 from then on.
- R8: In self-test mode, a `st_fail` pulse sets error to 1 and loads error type from `st_phase` (0 = compare-match phase, 1 = compare-mismatch phase). This also applies when `st_fail` arrives together with `st_done`.
- R9: Once error or complete is 1 in a run, later `st_fail` pulses change neither error nor error type until the mode leaves self-test.
- R10: Bus writes never change the complete, error or error-type bits, in either privilege level.
- R11: While `rst_n` is low at a clock edge, all flags become 0.
- R12: Writes to any address other than `REG_ADDR` leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | 1 = privileged access |
| bus_rdata | output | DATA_W | Combinational read data |
| cmp_mismatch | input | 1 | Comparator disagreement pulse |
| mode_selftest | input | 1 | 1 = self-test mode, 0 = any other mode |
| st_done | input | 1 | Self-test finished pulse |
| st_fail | input | 1 | Self-test failure pulse |
| st_phase | input | 1 | Current phase: 0 match, 1 mismatch |

## Verification
The bench targets the same-cycle collision of a mismatch with a privileged clear. A design that lets the clear win would lose an error there. It also checks the one cycle after the mode drops out of self-test: a design that clears on the next edge but reads the register without gating by mode would still show the stale complete bit in that cycle. Further checks cover failure pulses that arrive after the first recorded failure, or after completion, which a design without freezing would let overwrite the error type. Finally, user-level writes, writes of zero, and writes to a wrong address are each checked for leaving the compare error unchanged.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   localparam int unsigned LCS_DATA_W   = 32;
   localparam int unsigned LCS_CE_BIT   = 16;
   localparam int unsigned LCS_STC_BIT  = 8;
   localparam int unsigned LCS_STET_BIT = 1;
   localparam int unsigned LCS_STE_BIT  = 0;

   typedef struct packed {
      logic cmp_err;
      logic st_cmpl;
      logic st_etype;
      logic st_err;
   } lcs_flags_t;
endpackage

// File: rtl/lcs_err_flag.sv
module lcs_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> flag_o);
endmodule

// File: rtl/lcs_selftest_flags.sv
module lcs_selftest_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic done_i,
   input  logic fail_i,
   input  logic phase_i,
   output logic cmpl_o,
   output logic err_o,
   output logic etype_o
);
   logic capture_open;
   assign capture_open = !err_o && !cmpl_o;

   always_ff @(posedge clk) begin
      if (!rst_n || !active_i) begin
         cmpl_o  <= 1'b0;
         err_o   <= 1'b0;
         etype_o <= 1'b0;
      end else begin
         if (fail_i && capture_open) begin
            err_o   <= 1'b1;
            etype_o <= phase_i;
         end
         if (done_i)
            cmpl_o <= 1'b1;
      end
   end

   assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> (!cmpl_o && !err_o && !etype_o));
   assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && done_i) |=> cmpl_o);
   assert_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && fail_i && !err_o && !cmpl_o) |=> (err_o && etype_o == $past(phase_i)));
   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && (err_o || cmpl_o)) |=> ($stable(err_o) && $stable(etype_o)));
endmodule

// File: rtl/lcs_read_mux.sv
module lcs_read_mux
   import lcs_pkg::*;
#(
   parameter int unsigned DATA_W      = LCS_DATA_W,
   parameter int unsigned CE_BIT      = LCS_CE_BIT,
   parameter int unsigned STC_BIT     = LCS_STC_BIT,
   parameter int unsigned STET_BIT    = LCS_STET_BIT,
   parameter int unsigned STE_BIT     = LCS_STE_BIT,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic              hit_i,
   input  logic              active_i,
   input  lcs_flags_t        flags_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [DATA_W-1:0] MASK = (DATA_W'(1) << CE_BIT) | (DATA_W'(1) << STC_BIT)
                                      | (DATA_W'(1) << STET_BIT) | (DATA_W'(1) << STE_BIT);
   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      word[CE_BIT]   = flags_i.cmp_err;
      word[STC_BIT]  = flags_i.st_cmpl  & active_i;
      word[STET_BIT] = flags_i.st_etype & active_i;
      word[STE_BIT]  = flags_i.st_err   & active_i;
   end

   generate
      if (FULL_DECODE) begin : g_full
         assign rdata_o = hit_i ? word : '0;
      end else begin : g_alias
         logic unused_hit;
         assign unused_hit = hit_i;
         assign rdata_o = word;
      end
   endgenerate

   always_comb begin
      assert_reserved_zero_R1: assert ((rdata_o & ~MASK) == '0);
   end
endmodule

// File: rtl/lockstep_cmp_status.sv
module lockstep_cmp_status
   import lcs_pkg::*;
#(
   parameter int unsigned     ADDR_W      = 8,
   parameter int unsigned     DATA_W      = LCS_DATA_W,
   parameter logic [ADDR_W-1:0] REG_ADDR  = '0,
   parameter int unsigned     CE_BIT      = LCS_CE_BIT,
   parameter int unsigned     STC_BIT     = LCS_STC_BIT,
   parameter int unsigned     STET_BIT    = LCS_STET_BIT,
   parameter int unsigned     STE_BIT     = LCS_STE_BIT,
   parameter bit              FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmp_mismatch,
   input  logic              mode_selftest,
   input  logic              st_done,
   input  logic              st_fail,
   input  logic              st_phase
);
   generate
      if (CE_BIT >= DATA_W || STC_BIT >= DATA_W || STET_BIT >= DATA_W || STE_BIT >= DATA_W)
         begin : g_bad_pos
         $error("lockstep_cmp_status: flag bit outside data word");
      end
      if (CE_BIT == STC_BIT || CE_BIT == STET_BIT || CE_BIT == STE_BIT ||
          STC_BIT == STET_BIT || STC_BIT == STE_BIT || STET_BIT == STE_BIT) begin : g_bad_overlap
         $error("lockstep_cmp_status: flag bits overlap");
      end
      if (ADDR_W == 0) begin : g_bad_addr
         $error("lockstep_cmp_status: address width must be nonzero");
      end
   endgenerate

   logic       hit;
   logic       clr_req;
   lcs_flags_t flags;
   logic       unused_wdata;

   assign hit          = (bus_addr == REG_ADDR);
   assign clr_req      = bus_wr && hit && bus_priv && bus_wdata[CE_BIT];
   assign unused_wdata = ^bus_wdata;

   lcs_err_flag u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (cmp_mismatch),
      .clr_i  (clr_req),
      .flag_o (flags.cmp_err)
   );

   lcs_selftest_flags u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (mode_selftest),
      .done_i   (st_done),
      .fail_i   (st_fail),
      .phase_i  (st_phase),
      .cmpl_o   (flags.st_cmpl),
      .err_o    (flags.st_err),
      .etype_o  (flags.st_etype)
   );

   lcs_read_mux #(
      .DATA_W      (DATA_W),
      .CE_BIT      (CE_BIT),
      .STC_BIT     (STC_BIT),
      .STET_BIT    (STET_BIT),
      .STE_BIT     (STE_BIT),
      .FULL_DECODE (FULL_DECODE)
   ) u_rd (
      .hit_i    (hit),
      .active_i (mode_selftest),
      .flags_i  (flags),
      .rdata_o  (bus_rdata)
   );

   assert_user_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.cmp_err && bus_wr && !bus_priv) |=> flags.cmp_err);
   assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.cmp_err && bus_wr && !hit) |=> flags.cmp_err);
   assert_stc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_selftest |-> (bus_rdata[STC_BIT] == 1'b0));
   assert_st_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mode_selftest && !st_done && !st_fail && (flags.st_err || flags.st_cmpl))
      |=> ($stable(flags.st_err) && $stable(flags.st_etype)));
   assert_reset_R11: assert property (@(posedge clk)
      !rst_n |=> (!flags.cmp_err && !flags.st_cmpl && !flags.st_err && !flags.st_etype));
endmodule

// File: tb/tb_lockstep_cmp_status.sv
module tb_lockstep_cmp_status;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic        bus_priv;
   logic [31:0] bus_rdata;
   logic        cmp_mismatch, mode_selftest, st_done, st_fail, st_phase;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_ce = 0, m_stc = 0, m_ste = 0, m_stet = 0;

   always #5 clk = ~clk;

   lockstep_cmp_status dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
      .cmp_mismatch(cmp_mismatch), .mode_selftest(mode_selftest),
      .st_done(st_done), .st_fail(st_fail), .st_phase(st_phase)
   );

   function automatic logic [31:0] expect_word();
      logic [31:0] w = '0;
      if (bus_addr != 8'h00) return '0;
      if (m_ce != 0) w[16] = 1'b1;
      if (mode_selftest) begin
         if (m_stc != 0)  w[8] = 1'b1;
         if (m_stet != 0) w[1] = 1'b1;
         if (m_ste != 0)  w[0] = 1'b1;
      end
      return w;
   endfunction

   task automatic model_update();
      bit clr;
      if (!rst_n) begin
         m_ce = 0; m_stc = 0; m_ste = 0; m_stet = 0;
         return;
      end
      clr = bus_wr && bus_addr == 8'h00 && bus_priv && bus_wdata[16];
      if (cmp_mismatch) m_ce = 1;
      else if (clr) m_ce = 0;
      if (!mode_selftest) begin
         m_stc = 0; m_ste = 0; m_stet = 0;
      end else begin
         if (st_fail && m_ste == 0 && m_stc == 0) begin
            m_ste = 1; m_stet = st_phase ? 1 : 0;
         end
         if (st_done) m_stc = 1;
      end
   endtask

   task automatic step(input string tag, input bit chk, input bit rst,
                       input logic [7:0] a, input bit wr, input bit pv, input logic [31:0] wd,
                       input bit mm, input bit md, input bit dn, input bit fl, input bit ph);
      logic [31:0] exp;
      @(negedge clk);
      rst_n = ~rst; bus_addr = a; bus_wr = wr; bus_priv = pv; bus_wdata = wd;
      cmp_mismatch = mm; mode_selftest = md; st_done = dn; st_fail = fl; st_phase = ph;
      #1;
      if (chk) begin
         exp = expect_word();
         checks++;
         if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata actual=%h expected=%h", tag, bus_rdata, exp);
         end
      end
      model_update();
   endtask

   task automatic idle(input string tag, input bit md);
      step(tag, 1, 0, 8'h00, 0, 0, '0, 0, md, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      step("R11 reset", 0, 1, 8'h00, 0, 0, '0, 0, 0, 0, 0, 0);
      step("R11 reset", 1, 1, 8'h00, 0, 0, '0, 1, 1, 1, 1, 1);
      idle("R11 after reset", 0);
      // R2 sticky set
      step("R2 set", 1, 0, 8'h00, 0, 0, '0, 1, 0, 0, 0, 0);
      idle("R2 sticky", 0);
      idle("R2 sticky", 0);
      // R4 user write with bit set
      step("R4 user write", 1, 0, 8'h00, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      idle("R4 no effect", 0);
      // R3 privileged write of zero then one
      step("R3 write zero", 1, 0, 8'h00, 1, 1, 32'hFFFE_FFFF, 0, 0, 0, 0, 0);
      idle("R3 unchanged", 0);
      step("R3 clear", 1, 0, 8'h00, 1, 1, 32'h0001_0000, 0, 0, 0, 0, 0);
      idle("R3 cleared", 0);
      // R5 collision
      step("R5 collide", 1, 0, 8'h00, 1, 1, 32'h0001_0000, 1, 0, 0, 0, 0);
      idle("R5 set wins", 0);
      // R12 wrong address, R1 read elsewhere
      step("R12 other addr", 1, 0, 8'h04, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      step("R1 read other addr", 1, 0, 8'h04, 0, 0, '0, 0, 1, 0, 0, 0);
      idle("R12 unchanged", 0);
      step("R3 clear", 1, 0, 8'h00, 1, 1, 32'h0001_0000, 0, 0, 0, 0, 0);
      // R7 complete
      idle("R7 in progress", 1);
      step("R7 done", 1, 0, 8'h00, 0, 0, '0, 0, 1, 1, 0, 0);
      idle("R7 complete", 1);
      idle("R6 left mode", 0);
      idle("R6 reentry clean", 1);
      // R8 fail in mismatch phase, R9 freeze, R10 writes
      step("R8 fail ph1", 1, 0, 8'h00, 0, 0, '0, 0, 1, 0, 1, 1);
      idle("R8 recorded", 1);
      step("R9 second fail", 1, 0, 8'h00, 0, 0, '0, 0, 1, 0, 1, 0);
      idle("R9 frozen", 1);
      step("R7 done after fail", 1, 0, 8'h00, 0, 0, '0, 0, 1, 1, 0, 0);
      step("R10 priv write", 1, 0, 8'h00, 1, 1, 32'h0000_0000, 0, 1, 0, 0, 0);
      step("R10 user write", 1, 0, 8'h00, 1, 0, 32'hFFFF_FFFF, 0, 1, 0, 0, 0);
      idle("R10 unchanged", 1);
      step("R9 fail after done", 1, 0, 8'h00, 0, 0, '0, 0, 1, 0, 1, 1);
      idle("R9 unchanged", 1);
      idle("R6 left mode", 0);
      idle("R6 cleared", 0);
      // R8 fail with done same cycle, match phase
      idle("R6 new run", 1);
      step("R8 fail+done ph0", 1, 0, 8'h00, 0, 0, '0, 0, 1, 1, 1, 0);
      idle("R8 ph0 recorded", 1);
      step("R11 reset mid run", 1, 1, 8'h00, 0, 0, '0, 0, 1, 0, 0, 0);
      idle("R11 cleared", 1);
      // mixed pseudo-random traffic against the model
      lfsr = 32'hACE1_2357;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step("R2 R3 R4 R5 R8 R9 random", 1, 0, lfsr[3] ? 8'h00 : 8'h08, lfsr[4], lfsr[5],
              {lfsr[15:0], lfsr[31:16]}, lfsr[6] & lfsr[7], lfsr[8] | lfsr[9] | lfsr[10],
              lfsr[11] & lfsr[12], lfsr[13] & lfsr[14], lfsr[15]);
      end
      @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule